// File: doc/BRIEF.md
# PCI Configuration-Space Target

This block answers PCI configuration cycles addressed to a single-function device. It watches the shared bus for the first clock of FRAME#, latches the dword index, the command and the IDSEL line, and claims only type-0 configuration reads and writes aimed at it. A claimed cycle always has the same shape. DEVSEL# goes low after the turnaround clock, and TRDY# follows two clocks later with STOP# beside it, so the master must end after one data phase. After the transfer the three control lines are driven high for one clock before their output enable drops.

Behind the bus logic sits a type-0 header. It holds identification values fixed by parameters, a command register with four writable enables, and a status register whose event bits are set by neighbouring logic and cleared by software writing ones. It also holds a latency timer, a memory BAR and an I/O BAR that each decode on their top twelve bits, and the interrupt and grant bytes. The command bits, both BAR bases and a latency-expiry flag are brought out for the rest of the chip.

Top module: `pcfg_target`

## Requirements
- R1: A cycle is claimed only when, on the first clock with frame_n low, idsel is high and cbe_n is 4'hA (read) or 4'hB (write); any other cycle leaves ctl_oe and ad_oe low.
- R2: Counting the clock that samples the address as edge 0, devsel_n goes low after edge 1 and trdy_n and stop_n go low together after edge 3.
- R3: trdy_n and stop_n stay low until a clock edge sees irdy_n low; only that one data phase is transferred.
- R4: In the clock after the transfer edge, ctl_oe is high and devsel_n, trdy_n and stop_n are all high; one clock later ctl_oe and ad_oe are low.
- R5: A read drives ad_oe over the same clocks as ctl_oe and places the addressed dword on ad_out. Defaults: dword 0 = 0001_B325h, dword 2 = FF00_0001h, dword 3 = 0, dword 11 = 0, dword 15 = 0010_01FFh.
- R6: Command (dword 1, bits 15:0) keeps only bits 1, 2, 6 and 8 from writes; its other bits read 0. Dword 0 and dword 2 ignore writes.
- R7: Status (dword 1, bits 31:16) resets to 0. stat_set bits 8, 12, 13, 14 and 15 set the matching bit; a written 1 clears a bit, a written 0 leaves it; all other status bits read 0.
- R8: The latency timer (dword 3, bits 15:8) keeps written bits 7:3 and reads 0 in bits 2:0.
- R9: BAR0 (dword 4) and BAR1 (dword 5) keep written bits 31:20; BAR0 reads 0 in bits 19:0, and BAR1 reads 1 in bit 0 and 0 in bits 19:1.
- R10: A write changes only byte lanes whose active-low enable in cbe_n (bit n for bits 8n+7:8n) is 0 during the data phase. The interrupt line byte (dword 15, bits 7:0) is writable. Dwords with no register read 0.
- R11: While mst_busy is high, a counter loaded from the latency timer drops by one per clock. lat_expired is high once it reaches 0, and is low whenever mst_busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle framing from the master |
| irdy_n | input | 1 | Initiator ready |
| idsel | input | 1 | Configuration chip select |
| ad_in | input | 32 | Sampled address/data bus |
| cbe_n | input | 4 | Command / byte enables |
| stat_set | input | 16 | Status event pulses from other logic |
| mst_busy | input | 1 | High while this device owns the bus as master |
| ad_out | output | 32 | Read data toward the bus |
| ad_oe | output | 1 | Enable for ad_out |
| devsel_n | output | 1 | Device select |
| trdy_n | output | 1 | Target ready |
| stop_n | output | 1 | Stop / disconnect |
| ctl_oe | output | 1 | Enable for devsel_n, trdy_n and stop_n |
| cmd_q | output | 16 | Current command register |
| bar0_base | output | 12 | Memory window base bits 31:20 |
| bar1_base | output | 12 | I/O window base bits 31:20 |
| lat_expired | output | 1 | Latency count has run out |

## Verification
The checker watches the bus handshake on every clock. It checks that a claim follows a selected first FRAME# clock, that TRDY# comes two clocks behind DEVSEL#, that TRDY# and STOP# stay low while IRDY# is high, that the release clock follows the transfer, and that the data enable stays inside the control enable. The bench scenarios show the register contents: default values, writable-bit masks, clear-on-one status, byte-lane selection, reads of dwords with no register, and the exact clock on which the latency count expires.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_TURN, S_DEVS, S_WAIT, S_DATA, S_BACK
  } tgt_state_e;

  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  localparam logic [15:0] CMD_RW_MASK  = 16'h0146;
  localparam logic [15:0] STAT_MASK    = 16'hF100;
  localparam logic [7:0]  LAT_RW_MASK  = 8'hF8;

  function automatic logic is_cfg_cmd(input logic [3:0] cmd, input logic sel);
    return sel && ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR));
  endfunction

  // expand active-low byte enables into a bit mask of written bits
  function automatic logic [31:0] lane_mask(input logic [3:0] be_n);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = be_n[i] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be_n);
    logic [31:0] m;
    m = lane_mask(be_n);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             idsel,
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic             ad_oe,
  output logic             wr_fire,
  output logic [IDX_W-1:0] idx
);

  tgt_state_e       state_q;
  logic             frame_prev_q;
  logic             is_wr_q;
  logic [IDX_W-1:0] idx_q;

  // named internal events
  logic start_evt;
  logic claim_evt;
  logic xfer_evt;

  assign start_evt = frame_prev_q && !frame_n;
  assign claim_evt = start_evt && is_cfg_cmd(cbe_n, idsel);
  assign xfer_evt  = (state_q == S_DATA) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      frame_prev_q <= 1'b1;
      is_wr_q      <= 1'b0;
      idx_q        <= '0;
    end else begin
      frame_prev_q <= frame_n;
      case (state_q)
        S_IDLE: if (claim_evt) begin
          state_q <= S_TURN;
          idx_q   <= ad_in[IDX_W+1:2];
          is_wr_q <= cbe_n[0];
        end
        S_TURN:  state_q <= S_DEVS;
        S_DEVS:  state_q <= S_WAIT;
        S_WAIT:  state_q <= S_DATA;
        S_DATA:  if (xfer_evt) state_q <= S_BACK;
        S_BACK:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl_oe   = (state_q == S_DEVS) || (state_q == S_WAIT) ||
               (state_q == S_DATA) || (state_q == S_BACK);
    devsel_n = !((state_q == S_DEVS) || (state_q == S_WAIT) || (state_q == S_DATA));
    trdy_n   = (state_q != S_DATA);
    stop_n   = (state_q != S_DATA);
    ad_oe    = ctl_oe && !is_wr_q;
  end

  assign wr_fire = xfer_evt && is_wr_q;
  assign idx     = idx_q;

endmodule

// File: rtl/pcfg_regs.sv
module pcfg_regs
  import pcfg_pkg::*;
#(
  parameter int          IDX_W       = 6,
  parameter int          BAR_W       = 12,
  parameter int          LAT_W       = 8,
  parameter logic [15:0] VEND_ID     = 16'hB325,
  parameter logic [15:0] DEV_ID      = 16'h0001,
  parameter logic [7:0]  REV_ID      = 8'h01,
  parameter logic [23:0] CLASS_CODE  = 24'hFF0000,
  parameter logic [15:0] SUB_VEND_ID = 16'h0000,
  parameter logic [15:0] SUB_ID      = 16'h0000,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [3:0]       be_n,
  input  logic [15:0]      stat_set,
  input  logic             mst_busy,
  output logic [31:0]      rdata,
  output logic [15:0]      cmd_q,
  output logic [BAR_W-1:0] bar0_base,
  output logic [BAR_W-1:0] bar1_base,
  output logic             lat_expired
);

  localparam int BAR_LO = 32 - BAR_W;

  localparam logic [IDX_W-1:0] IX_ID   = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_CS   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_CLS  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_MISC = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_BAR0 = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_BAR1 = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_SUB  = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_INT  = IDX_W'(15);

  logic [15:0]      cmd_r, stat_r;
  logic [7:0]       lat_r, int_line_r;
  logic [BAR_W-1:0] bar0_r, bar1_r;
  logic [LAT_W-1:0] lat_cnt_q;

  logic [31:0] wmask;
  logic [31:0] cs_merge, misc_merge, bar0_merge, bar1_merge, int_merge;

  assign wmask      = lane_mask(be_n);
  assign cs_merge   = lane_merge({16'h0, cmd_r}, wdata, be_n);
  assign misc_merge = lane_merge({16'h0, lat_r, 8'h0}, wdata, be_n);
  assign bar0_merge = lane_merge({bar0_r, BAR_LO'(0)}, wdata, be_n);
  assign bar1_merge = lane_merge({bar1_r, BAR_LO'(0)}, wdata, be_n);
  assign int_merge  = lane_merge({24'h0, int_line_r}, wdata, be_n);

  logic [15:0] stat_clr;
  assign stat_clr = (wr_fire && idx == IX_CS) ? (wdata[31:16] & wmask[31:16]) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_r      <= '0;
      stat_r     <= '0;
      lat_r      <= '0;
      bar0_r     <= '0;
      bar1_r     <= '0;
      int_line_r <= 8'hFF;
    end else begin
      stat_r <= ((stat_r & ~stat_clr) | stat_set) & STAT_MASK;
      if (wr_fire) begin
        case (idx)
          IX_CS:   cmd_r      <= cs_merge[15:0] & CMD_RW_MASK;
          IX_MISC: lat_r      <= misc_merge[15:8] & LAT_RW_MASK;
          IX_BAR0: bar0_r     <= bar0_merge[31:BAR_LO];
          IX_BAR1: bar1_r     <= bar1_merge[31:BAR_LO];
          IX_INT:  int_line_r <= int_merge[7:0];
          default: ;
        endcase
      end
    end
  end

  // latency countdown while mastering
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_cnt_q <= '0;
    else if (!mst_busy)        lat_cnt_q <= LAT_W'(lat_r);
    else if (lat_cnt_q != '0)  lat_cnt_q <= lat_cnt_q - 1'b1;
  end
  assign lat_expired = mst_busy && (lat_cnt_q == '0);

  always_comb begin
    case (idx)
      IX_ID:   rdata = {DEV_ID, VEND_ID};
      IX_CS:   rdata = {stat_r, cmd_r};
      IX_CLS:  rdata = {CLASS_CODE, REV_ID};
      IX_MISC: rdata = {16'h0000, lat_r, 8'h00};
      IX_BAR0: rdata = {bar0_r, BAR_LO'(0)};
      IX_BAR1: rdata = {bar1_r, BAR_LO'(1)};
      IX_SUB:  rdata = {SUB_ID, SUB_VEND_ID};
      IX_INT:  rdata = {MAX_LAT, MIN_GNT, 8'h01, int_line_r};
      default: rdata = 32'h0;
    endcase
  end

  assign cmd_q     = cmd_r;
  assign bar0_base = bar0_r;
  assign bar1_base = bar1_r;

endmodule

// File: rtl/pcfg_target.sv
module pcfg_target
  import pcfg_pkg::*;
#(
  parameter int          IDX_W       = 6,
  parameter int          BAR_W       = 12,
  parameter int          LAT_W       = 8,
  parameter logic [15:0] VEND_ID     = 16'hB325,
  parameter logic [15:0] DEV_ID      = 16'h0001,
  parameter logic [7:0]  REV_ID      = 8'h01,
  parameter logic [23:0] CLASS_CODE  = 24'hFF0000,
  parameter logic [15:0] SUB_VEND_ID = 16'h0000,
  parameter logic [15:0] SUB_ID      = 16'h0000,
  parameter logic [7:0]  MIN_GNT     = 8'h10,
  parameter logic [7:0]  MAX_LAT     = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             idsel,
  input  logic [31:0]      ad_in,
  input  logic [3:0]       cbe_n,
  input  logic [15:0]      stat_set,
  input  logic             mst_busy,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             stop_n,
  output logic             ctl_oe,
  output logic [15:0]      cmd_q,
  output logic [BAR_W-1:0] bar0_base,
  output logic [BAR_W-1:0] bar1_base,
  output logic             lat_expired
);

  logic             wr_fire;
  logic [IDX_W-1:0] idx;

  pcfg_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .idsel    (idsel),
    .ad_in    (ad_in),
    .cbe_n    (cbe_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ctl_oe   (ctl_oe),
    .ad_oe    (ad_oe),
    .wr_fire  (wr_fire),
    .idx      (idx)
  );

  pcfg_regs #(
    .IDX_W(IDX_W), .BAR_W(BAR_W), .LAT_W(LAT_W),
    .VEND_ID(VEND_ID), .DEV_ID(DEV_ID), .REV_ID(REV_ID),
    .CLASS_CODE(CLASS_CODE), .SUB_VEND_ID(SUB_VEND_ID), .SUB_ID(SUB_ID),
    .MIN_GNT(MIN_GNT), .MAX_LAT(MAX_LAT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire     (wr_fire),
    .idx         (idx),
    .wdata       (ad_in),
    .be_n        (cbe_n),
    .stat_set    (stat_set),
    .mst_busy    (mst_busy),
    .rdata       (ad_out),
    .cmd_q       (cmd_q),
    .bar0_base   (bar0_base),
    .bar1_base   (bar1_base),
    .lat_expired (lat_expired)
  );

endmodule

// File: rtl/pcfg_target_chk.sv
module pcfg_target_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_n,
  input logic irdy_n,
  input logic idsel,
  input logic devsel_n,
  input logic trdy_n,
  input logic stop_n,
  input logic ctl_oe,
  input logic ad_oe
);

  AST_CLAIM_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe) |-> ($past(idsel, 2) && !$past(frame_n, 2))); // R1

  AST_TRDY_AFTER_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> (!devsel_n && !$past(devsel_n, 2) && !stop_n)); // R2

  AST_HOLD_UNTIL_IRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && !trdy_n && irdy_n) |=> (!trdy_n && !stop_n)); // R3

  AST_BACKOFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && !trdy_n && !irdy_n) |=> (ctl_oe && devsel_n && trdy_n && stop_n)); // R4

  AST_RELEASE_AFTER_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && devsel_n && !$rose(ctl_oe)) |=> (!ctl_oe && !ad_oe)); // R4

  AST_AD_INSIDE_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> ctl_oe); // R5

endmodule

bind pcfg_target pcfg_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_n  (frame_n),
  .irdy_n   (irdy_n),
  .idsel    (idsel),
  .devsel_n (devsel_n),
  .trdy_n   (trdy_n),
  .stop_n   (stop_n),
  .ctl_oe   (ctl_oe),
  .ad_oe    (ad_oe)
);

// File: tb/pcfg_target_tb_top.sv
`timescale 1ns/1ps
module pcfg_target_tb_top;

  localparam real CYC = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        idsel = 1'b0;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n = '0;
  logic [15:0] stat_set = '0;
  logic        mst_busy = 1'b0;
  logic [31:0] ad_out;
  logic        ad_oe, devsel_n, trdy_n, stop_n, ctl_oe, lat_expired;
  logic [15:0] cmd_q;
  logic [11:0] bar0_base, bar1_base;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  pcfg_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .idsel(idsel), .ad_in(ad_in), .cbe_n(cbe_n), .stat_set(stat_set),
    .mst_busy(mst_busy), .ad_out(ad_out), .ad_oe(ad_oe),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ctl_oe(ctl_oe),
    .cmd_q(cmd_q), .bar0_base(bar0_base), .bar1_base(bar1_base),
    .lat_expired(lat_expired)
  );

  // {is_write, dword index, byte enables (active low), write data, expected read}
  localparam int NV = 26;
  localparam logic [74:0] VEC [NV] = '{
    {1'b0, 6'd0,  4'h0, 32'h0,         32'h0001_B325},  // R5 ids
    {1'b0, 6'd1,  4'h0, 32'h0,         32'h0000_0000},  // R7 status reset
    {1'b0, 6'd2,  4'h0, 32'h0,         32'hFF00_0001},  // R5 class/rev
    {1'b0, 6'd3,  4'h0, 32'h0,         32'h0000_0000},  // R8
    {1'b0, 6'd4,  4'h0, 32'h0,         32'h0000_0000},  // R9
    {1'b0, 6'd5,  4'h0, 32'h0,         32'h0000_0001},  // R9
    {1'b0, 6'd11, 4'h0, 32'h0,         32'h0000_0000},  // R5 subsystem
    {1'b0, 6'd15, 4'h0, 32'h0,         32'h0010_01FF},  // R5 int/grant
    {1'b1, 6'd1,  4'h0, 32'hFFFF_FFFF, 32'h0},          // R6
    {1'b0, 6'd1,  4'h0, 32'h0,         32'h0000_0146},  // R6
    {1'b1, 6'd4,  4'h0, 32'hFFFF_FFFF, 32'h0},          // R9
    {1'b0, 6'd4,  4'h0, 32'h0,         32'hFFF0_0000},  // R9
    {1'b1, 6'd5,  4'h0, 32'hFFFF_FFFF, 32'h0},          // R9
    {1'b0, 6'd5,  4'h0, 32'h0,         32'hFFF0_0001},  // R9
    {1'b1, 6'd3,  4'h0, 32'hFFFF_FFFF, 32'h0},          // R8
    {1'b0, 6'd3,  4'h0, 32'h0,         32'h0000_F800},  // R8
    {1'b1, 6'd15, 4'h0, 32'h1234_5678, 32'h0},          // R10
    {1'b0, 6'd15, 4'h0, 32'h0,         32'h0010_0178},  // R10
    {1'b1, 6'd0,  4'h0, 32'hFFFF_FFFF, 32'h0},          // R6 read-only
    {1'b0, 6'd0,  4'h0, 32'h0,         32'h0001_B325},  // R6
    {1'b1, 6'd4,  4'h7, 32'h0000_0000, 32'h0},          // R10 lane 3 only
    {1'b0, 6'd4,  4'h0, 32'h0,         32'h00F0_0000},  // R10
    {1'b1, 6'd20, 4'h0, 32'hFFFF_FFFF, 32'h0},          // R10 empty dword
    {1'b0, 6'd20, 4'h0, 32'h0,         32'h0000_0000},  // R10
    {1'b1, 6'd1,  4'hD, 32'h0000_0000, 32'h0},          // R10 lane 1 only
    {1'b0, 6'd1,  4'h0, 32'h0,         32'h0000_0046}   // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [5:0] idx, input logic [3:0] be,
                      input logic [31:0] wd, input int hold, output logic [31:0] rd);
    @(negedge clk);
    frame_n = 1'b0; idsel = 1'b1; ad_in = {24'h0, idx, 2'b00};
    cbe_n = wr ? 4'hB : 4'hA;
    @(negedge clk);
    frame_n = 1'b1; idsel = 1'b0; cbe_n = be; ad_in = wr ? wd : 32'h0;
    irdy_n = (hold == 0) ? 1'b0 : 1'b1;
    check("R2 devsel high in turnaround", {31'h0, devsel_n}, 32'h1);
    @(negedge clk);
    check("R2 devsel low after edge 1", {31'h0, devsel_n}, 32'h0);
    check("R2 trdy high at devsel", {31'h0, trdy_n}, 32'h1);
    check("R5 ad_oe on read only", {31'h0, ad_oe}, {31'h0, !wr});
    @(negedge clk);
    check("R2 trdy still high", {31'h0, trdy_n}, 32'h1);
    @(negedge clk);
    check("R2 trdy/stop low after edge 3", {30'h0, trdy_n, stop_n}, 32'h0);
    rd = ad_out;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R3 trdy/stop held while irdy high", {30'h0, trdy_n, stop_n}, 32'h0);
    end
    irdy_n = 1'b0;
    @(negedge clk);
    check("R4 backoff drives all high", {28'h0, ctl_oe, devsel_n, trdy_n, stop_n}, 32'hF);
    irdy_n = 1'b1; ad_in = '0; cbe_n = '0;
    @(negedge clk);
    check("R4 released", {30'h0, ctl_oe, ad_oe}, 32'h0);
  endtask

  task automatic no_claim(input logic sel, input logic [3:0] cmd, input string tag);
    @(negedge clk);
    frame_n = 1'b0; idsel = sel; ad_in = 32'h0; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; idsel = 1'b0; irdy_n = 1'b0; cbe_n = 4'h0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(tag, {30'h0, ctl_oe, ad_oe}, 32'h0);
    end
    irdy_n = 1'b1;
  endtask

  logic [31:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset outputs released", {30'h0, ctl_oe, ad_oe}, 32'h0);
    check("R11 reset lat_expired", {31'h0, lat_expired}, 32'h0);
    check("R6 reset cmd_q", {16'h0, cmd_q}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][74], VEC[v][73:68], VEC[v][67:64], VEC[v][63:32], v % 3, rd);
      if (!VEC[v][74]) check($sformatf("R5/R6-R10 vector %0d read", v), rd, VEC[v][31:0]);
    end
    check("R6 cmd_q port", {16'h0, cmd_q}, 32'h0000_0046);
    check("R9 bar0_base port", {20'h0, bar0_base}, 32'h0000_000F);
    check("R9 bar1_base port", {20'h0, bar1_base}, 32'h0000_0FFF);

    // R1: unclaimed cycles
    no_claim(1'b0, 4'hA, "R1 no claim without idsel");
    no_claim(1'b1, 4'h6, "R1 no claim for memory read");
    no_claim(1'b1, 4'h2, "R1 no claim for io read");

    // R7: status set / clear-on-one
    @(negedge clk); stat_set = 16'hF100;
    @(negedge clk); stat_set = 16'h00FF;
    @(negedge clk); stat_set = 16'h0;
    xfer(1'b0, 6'd1, 4'h0, 32'h0, 0, rd);
    check("R7 status set, unimplemented bits stay 0", rd, 32'hF100_0046);
    xfer(1'b1, 6'd1, 4'h3, 32'h4000_0000, 0, rd);
    xfer(1'b0, 6'd1, 4'h0, 32'h0, 0, rd);
    check("R7 write 1 clears bit 14 only", rd, 32'hB100_0046);
    xfer(1'b1, 6'd1, 4'h3, 32'h0000_0000, 0, rd);
    xfer(1'b0, 6'd1, 4'h0, 32'h0, 0, rd);
    check("R7 write 0 leaves status", rd, 32'hB100_0046);
    xfer(1'b1, 6'd1, 4'h3, 32'hB100_0000, 0, rd);
    xfer(1'b0, 6'd1, 4'h0, 32'h0, 0, rd);
    check("R7 clear all status", rd, 32'h0000_0046);

    // R11: latency countdown from F8h = 248
    @(negedge clk); mst_busy = 1'b1;
    repeat (247) @(negedge clk);
    check("R11 not expired after 247 clocks", {31'h0, lat_expired}, 32'h0);
    @(negedge clk);
    check("R11 expired after 248 clocks", {31'h0, lat_expired}, 32'h1);
    mst_busy = 1'b0;
    @(negedge clk);
    check("R11 idle when not mastering", {31'h0, lat_expired}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule